// File: doc/BRIEF.md
# Cursor-Gated Transmit Character Extractor

This block takes text characters from a recirculating display memory and feeds them into a three-stage holding pipeline. The pipeline's last stage drives a serial transmitter. A character is taken from memory only when three things are true: the display cursor sits at the entry position, the first stage can be emptied in the same clock, and no stop condition is pending. Each stage carries its own occupancy bit. Characters move one stage toward the transmitter whenever the stage ahead is free, and the transmitter empties the last stage with a one-cycle strobe.

An end-of-text code stops extraction at the next third-slot strobe. A line-feed code pauses extraction until the next fourth-slot strobe and asks the cursor logic to advance to the start of the next line, so the rest of the line is never sent. A polling read forces a fixed header into the three stages and blocks extraction until the memory scan reports an operator-entered end code. After that report, text overwrites the forced end code in the first stage. A time-out pulse that arrives once the pipeline is empty returns the block to idle.

Top module: `tx_char_extractor`

## Requirements
- R1: After reset all busy bits are 0, `shift_en_o`, `end_o`, `done_o` and `adv_req_o` are 0, and `shift_en_o` stays 0 until a transmit start or a polling read.
- R2: Characters enter stage 1, move to stage 2 and then to stage 3 on the clock after the stage ahead is free. Stage 3 holds until `tx_taken_i`. Characters leave stage 3 in the order they were taken from memory.
- R3: While all three busy bits are set and `tx_taken_i` is low, `shift_en_o` is 0. With `tx_taken_i` high in the same cycle, the whole pipeline moves and `shift_en_o` may be 1.
- R4: `shift_en_o` requires the block to be active and `cursor_i` high. A second character is taken on the next clock of the same cursor visit while stage 1 is busy but stage 2 is free.
- R5: Taking ETX (0x03) from memory blocks further extraction. At the next `slot3_i` strobe, `end_o` rises and extraction stays blocked. `done_o` is `end_o` with all busy bits 0.
- R6: `timeout_i` with all busy bits 0 clears `end_o` and makes the block idle, so `shift_en_o` is 0 even with the cursor present. `timeout_i` while any stage is busy has no effect.
- R7: Taking LF (0x0A) blocks extraction. At the next `slot3_i`, a one-character inhibit is set and `adv_req_o` pulses for one cycle with `adv_cnt_o` = max(1, 88 − `col_i`). The next `slot4_i` clears the inhibit and extraction resumes.
- R8: `poll_read_i` loads stage 3 with STX (0x02), stage 2 with the device address parameter and stage 1 with ETX (0x03). It sets all busy bits, sets `end_o` and blocks extraction.
- R9: `op_etx_found_i` while `end_o` is set and the block is active clears busy bit 1 and `end_o`. The next extraction overwrites the ETX held in stage 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xmit_start_i | input | 1 | Start a normal transmit (sets active) |
| poll_read_i | input | 1 | Polling read command; forces the header |
| op_etx_found_i | input | 1 | Memory scan found an operator end code |
| timeout_i | input | 1 | Transmit time-out pulse |
| cursor_i | input | 1 | Cursor is at the entry position |
| col_i | input | 7 | Current cursor column |
| slot3_i | input | 1 | Third-slot character timing strobe |
| slot4_i | input | 1 | Fourth-slot character timing strobe |
| mem_char_i | input | 7 | Character at the memory output |
| tx_taken_i | input | 1 | Transmitter took the stage 3 character |
| d1_o | output | 7 | Stage 1 character |
| d2_o | output | 7 | Stage 2 character |
| d3_o | output | 7 | Stage 3 character |
| busy_o | output | 3 | Busy bits; bit 0 is stage 1 |
| shift_en_o | output | 1 | Take `mem_char_i` into stage 1 on this clock |
| adv_req_o | output | 1 | Advance-line cursor request (one cycle) |
| adv_cnt_o | output | 7 | Cursor advance distance |
| end_o | output | 1 | End flag: extraction stopped |
| done_o | output | 1 | End flag set and pipeline empty |

## Verification
The bench fills the pipeline and then releases it with a take strobe in the same cycle. A design that frees stage 1 only from registered state would take one character per take, not a full cascade. A design that shifted from stage 1 first would drop or duplicate characters, and the bench would see the wrong letters in stages 2 and 3. It checks that a code taken from memory holds off extraction before any slot strobe, since a design that waited for the strobe would take the character after LF. It checks that a time-out with data still queued leaves the end flag set, and that `adv_cnt_o` is clamped to 1 for columns beyond the line length.

// File: rtl/txx_pkg.sv
package txx_pkg;
  localparam int unsigned CHAR_W = 7;
  typedef logic [CHAR_W-1:0] char_t;
  localparam char_t C_STX = 7'h02;
  localparam char_t C_ETX = 7'h03;
  localparam char_t C_LF  = 7'h0A;
endpackage

// File: rtl/txx_pipe.sv
module txx_pipe
  import txx_pkg::*;
#(
  parameter int unsigned NSTAGE = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  char_t                         load_char_i,
  input  logic                          take_i,
  input  logic                          jam_i,
  input  logic [NSTAGE-1:0][CHAR_W-1:0] jam_data_i,
  input  logic                          clr_first_i,
  output logic [NSTAGE-1:0][CHAR_W-1:0] data_o,
  output logic [NSTAGE-1:0]             busy_o,
  output logic                          first_free_o
);
  logic [NSTAGE-1:0] move, s_free;

  // resolve from the transmitter end backward so a full pipe can cascade
  always_comb begin
    logic nf;
    nf = take_i;
    for (int i = NSTAGE - 1; i >= 0; i--) begin
      move[i]   = busy_o[i] & nf;
      s_free[i] = ~busy_o[i] | move[i];
      nf        = s_free[i];
    end
  end
  assign first_free_o = s_free[0];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic  v_q, in_v, clr;
    char_t d_q, in_d;
    if (g == 0) begin : g_head
      assign in_v = load_i;
      assign in_d = load_char_i;
      assign clr  = clr_first_i;
    end else begin : g_body
      assign in_v = move[g-1];
      assign in_d = data_o[g-1];
      assign clr  = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (jam_i) begin
        v_q <= 1'b1;
        d_q <= jam_data_i[g];
      end else begin
        v_q <= (in_v | (v_q & ~move[g])) & ~clr;
        if (in_v) d_q <= in_d;
      end
    end
    assign busy_o[g] = v_q;
    assign data_o[g] = d_q;
  end

  AST_LAST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o[NSTAGE-1] && !take_i && !jam_i |=> busy_o[NSTAGE-1] && $stable(data_o[NSTAGE-1])); // R2
  AST_JAM_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_i |=> &busy_o); // R8
endmodule

// File: rtl/txx_ctrl.sv
module txx_ctrl
  import txx_pkg::*;
#(
  parameter int unsigned NSTAGE   = 3,
  parameter int unsigned LINE_LEN = 88,
  localparam int unsigned COL_W   = $clog2(LINE_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xmit_start_i,
  input  logic              poll_read_i,
  input  logic              op_etx_found_i,
  input  logic              timeout_i,
  input  logic              cursor_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              slot3_i,
  input  logic              slot4_i,
  input  char_t             mem_char_i,
  input  logic              take_i,
  input  logic [NSTAGE-1:0] busy_i,
  input  logic              first_free_i,
  output logic              shift_en_o,
  output logic              jam_o,
  output logic              clr_first_o,
  output logic              end_o,
  output logic              adv_req_o,
  output logic [COL_W-1:0]  adv_cnt_o
);
  logic active_q, end_q, lf_q, pend_etx_q, pend_lf_q, adv_req_q;
  logic [COL_W-1:0] adv_cnt_q, adv_calc;
  logic empty, go_idle;

  assign empty   = (busy_i == '0);
  assign go_idle = timeout_i & active_q & empty;
  assign jam_o   = poll_read_i;

  assign shift_en_o = active_q & cursor_i & first_free_i & ~end_q & ~lf_q
                    & ~pend_etx_q & ~pend_lf_q & ~poll_read_i;
  assign clr_first_o = op_etx_found_i & active_q & end_q & ~poll_read_i;

  always_comb begin
    if (col_i >= COL_W'(LINE_LEN - 1)) adv_calc = COL_W'(1);
    else                               adv_calc = COL_W'(LINE_LEN) - col_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      end_q      <= 1'b0;
      lf_q       <= 1'b0;
      pend_etx_q <= 1'b0;
      pend_lf_q  <= 1'b0;
      adv_req_q  <= 1'b0;
      adv_cnt_q  <= '0;
    end else if (poll_read_i) begin
      active_q   <= 1'b1;
      end_q      <= 1'b1;
      lf_q       <= 1'b0;
      pend_etx_q <= 1'b0;
      pend_lf_q  <= 1'b0;
      adv_req_q  <= 1'b0;
    end else begin
      adv_req_q <= 1'b0;
      if (xmit_start_i) active_q <= 1'b1;
      if (shift_en_o && mem_char_i == C_ETX) pend_etx_q <= 1'b1;
      if (shift_en_o && mem_char_i == C_LF)  pend_lf_q  <= 1'b1;
      if (slot4_i) lf_q <= 1'b0;
      if (slot3_i && pend_etx_q) begin
        end_q      <= 1'b1;
        pend_etx_q <= 1'b0;
      end
      if (slot3_i && pend_lf_q) begin
        lf_q      <= 1'b1;
        pend_lf_q <= 1'b0;
        adv_req_q <= 1'b1;
        adv_cnt_q <= adv_calc;
      end
      if (clr_first_o) end_q <= 1'b0;
      if (go_idle) begin
        active_q   <= 1'b0;
        end_q      <= 1'b0;
        lf_q       <= 1'b0;
        pend_etx_q <= 1'b0;
        pend_lf_q  <= 1'b0;
      end
    end
  end

  assign end_o     = end_q;
  assign adv_req_o = adv_req_q;
  assign adv_cnt_o = adv_cnt_q;

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&busy_i) && !take_i |-> !shift_en_o); // R3
  AST_END_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_etx_q && slot3_i && !poll_read_i && !go_idle && !clr_first_o |=> end_q); // R5
  AST_IDLE_AFTER_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_idle && !poll_read_i |=> !active_q && !end_q); // R6
  AST_ADV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_req_q |=> !adv_req_q); // R7
  AST_ADV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_req_q |-> adv_cnt_q >= COL_W'(1) && adv_cnt_q <= COL_W'(LINE_LEN)); // R7
  AST_POLL_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_read_i |=> end_q && active_q); // R8
endmodule

// File: rtl/tx_char_extractor.sv
module tx_char_extractor
  import txx_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h41,
  parameter int unsigned LINE_LEN = 88
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xmit_start_i,
  input  logic       poll_read_i,
  input  logic       op_etx_found_i,
  input  logic       timeout_i,
  input  logic       cursor_i,
  input  logic [6:0] col_i,
  input  logic       slot3_i,
  input  logic       slot4_i,
  input  logic [6:0] mem_char_i,
  input  logic       tx_taken_i,
  output logic [6:0] d1_o,
  output logic [6:0] d2_o,
  output logic [6:0] d3_o,
  output logic [2:0] busy_o,
  output logic       shift_en_o,
  output logic       adv_req_o,
  output logic [6:0] adv_cnt_o,
  output logic       end_o,
  output logic       done_o
);
  localparam int unsigned NSTAGE = 3;

  logic [NSTAGE-1:0][CHAR_W-1:0] data, jam_data;
  logic [NSTAGE-1:0] busy;
  logic first_free, jam, clr_first, shift_en;

  assign jam_data = {C_STX, char_t'(DEV_ADDR), C_ETX};

  txx_pipe #(.NSTAGE(NSTAGE)) i_pipe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (shift_en),
    .load_char_i  (mem_char_i),
    .take_i       (tx_taken_i),
    .jam_i        (jam),
    .jam_data_i   (jam_data),
    .clr_first_i  (clr_first),
    .data_o       (data),
    .busy_o       (busy),
    .first_free_o (first_free)
  );

  txx_ctrl #(.NSTAGE(NSTAGE), .LINE_LEN(LINE_LEN)) i_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .xmit_start_i   (xmit_start_i),
    .poll_read_i    (poll_read_i),
    .op_etx_found_i (op_etx_found_i),
    .timeout_i      (timeout_i),
    .cursor_i       (cursor_i),
    .col_i          (col_i),
    .slot3_i        (slot3_i),
    .slot4_i        (slot4_i),
    .mem_char_i     (mem_char_i),
    .take_i         (tx_taken_i),
    .busy_i         (busy),
    .first_free_i   (first_free),
    .shift_en_o     (shift_en),
    .jam_o          (jam),
    .clr_first_o    (clr_first),
    .end_o          (end_o),
    .adv_req_o      (adv_req_o),
    .adv_cnt_o      (adv_cnt_o)
  );

  assign d1_o       = data[0];
  assign d2_o       = data[1];
  assign d3_o       = data[2];
  assign busy_o     = busy;
  assign shift_en_o = shift_en;
  assign done_o     = end_o & (busy == '0);
endmodule

// File: tb/test_tx_char_extractor.sv
`timescale 1ns/1ps
module test_tx_char_extractor;
  localparam logic [6:0] ADDR = 7'h41;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xmit_start = 0, poll_read = 0, op_found = 0, timeout = 0, cursor = 0;
  logic slot3 = 0, slot4 = 0, tx_taken = 0;
  logic [6:0] col = '0, mem_char = '0;
  logic [6:0] d1, d2, d3, adv_cnt;
  logic [2:0] busy;
  logic shift_en, adv_req, end_f, done;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tx_char_extractor #(.DEV_ADDR(ADDR)) i_tx_char_extractor (
    .clk_i(clk), .rst_ni(rst_n), .xmit_start_i(xmit_start), .poll_read_i(poll_read),
    .op_etx_found_i(op_found), .timeout_i(timeout), .cursor_i(cursor), .col_i(col),
    .slot3_i(slot3), .slot4_i(slot4), .mem_char_i(mem_char), .tx_taken_i(tx_taken),
    .d1_o(d1), .d2_o(d2), .d3_o(d3), .busy_o(busy), .shift_en_o(shift_en),
    .adv_req_o(adv_req), .adv_cnt_o(adv_cnt), .end_o(end_f), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ceq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic t_reset;
    cursor = 1; #1;
    ceq("R1 busy", busy, 0);
    ceq("R1 shift_en idle", shift_en, 0);
    ceq("R1 end", end_f, 0);
    ceq("R1 done", done, 0);
    ceq("R1 adv_req", adv_req, 0);
    cursor = 0;
  endtask

  task automatic t_flow;
    xmit_start = 1; tick; xmit_start = 0;
    mem_char = 7'h41; #1;
    ceq("R4 no cursor", shift_en, 0);
    cursor = 1; #1;
    ceq("R4 cursor", shift_en, 1);
    tick; ceq("R2 d1 A", d1, 7'h41); ceq("R2 busy 001", busy, 3'b001);
    mem_char = 7'h42; #1;
    ceq("R4 second char", shift_en, 1);
    tick; ceq("R2 d2 A", d2, 7'h41); ceq("R2 d1 B", d1, 7'h42);
    mem_char = 7'h43; tick;
    ceq("R2 busy full", busy, 3'b111); ceq("R2 d3 A", d3, 7'h41);
    ceq("R2 d1 C", d1, 7'h43);
    mem_char = 7'h44; #1;
    ceq("R3 full hold", shift_en, 0);
    tick; ceq("R3 still A", d3, 7'h41);
    tx_taken = 1; #1;
    ceq("R3 cascade", shift_en, 1);
    tick; tx_taken = 0;
    ceq("R2 d3 B", d3, 7'h42); ceq("R2 d2 C", d2, 7'h43); ceq("R2 d1 D", d1, 7'h44);
    cursor = 0; tx_taken = 1; tick;
    ceq("R2 d3 C", d3, 7'h43); ceq("R2 busy 110", busy, 3'b110);
    tick; ceq("R2 d3 D", d3, 7'h44);
    tick; tx_taken = 0;
    ceq("R2 drained", busy, 0);
  endtask

  task automatic t_etx;
    cursor = 1; mem_char = 7'h03; #1;
    ceq("R5 load etx", shift_en, 1);
    tick; mem_char = 7'h45; #1;
    ceq("R5 pending blocks", shift_en, 0);
    ceq("R5 end before slot3", end_f, 0);
    slot3 = 1; tick; slot3 = 0;
    ceq("R5 end set", end_f, 1);
    ceq("R5 still blocked", shift_en, 0);
    timeout = 1; tick; timeout = 0;
    ceq("R6 busy timeout ignored", end_f, 1);
    ceq("R5 etx at d3", d3, 7'h03);
    tx_taken = 1; tick; tx_taken = 0;
    ceq("R5 done", done, 1);
    timeout = 1; tick; timeout = 0;
    ceq("R6 end cleared", end_f, 0);
    ceq("R6 idle", shift_en, 0);
    cursor = 0;
  endtask

  task automatic t_lf;
    xmit_start = 1; tick; xmit_start = 0;
    cursor = 1; col = 7'd80; mem_char = 7'h0A; #1;
    ceq("R7 load lf", shift_en, 1);
    tick; mem_char = 7'h58; #1;
    ceq("R7 pending blocks", shift_en, 0);
    slot3 = 1; tick; slot3 = 0;
    ceq("R7 adv req", adv_req, 1);
    ceq("R7 adv cnt 8", adv_cnt, 8);
    ceq("R7 inhibit", shift_en, 0);
    tick;
    ceq("R7 pulse one cycle", adv_req, 0);
    ceq("R7 inhibit held", shift_en, 0);
    slot4 = 1; tick; slot4 = 0; #1;
    ceq("R7 resume", shift_en, 1);
    tick; ceq("R7 d1 X", d1, 7'h58);
    col = 7'd95; mem_char = 7'h0A; #1;
    ceq("R7 second lf", shift_en, 1);
    tick; slot3 = 1; tick; slot3 = 0;
    ceq("R7 clamp 1", adv_cnt, 1);
    slot4 = 1; cursor = 0; tick; slot4 = 0;
    tx_taken = 1; repeat (4) tick; tx_taken = 0;
    ceq("R7 drained", busy, 0);
    timeout = 1; tick; timeout = 0;
  endtask

  task automatic t_poll;
    cursor = 1; mem_char = 7'h48; poll_read = 1; tick; poll_read = 0; #1;
    ceq("R8 d3 stx", d3, 7'h02); ceq("R8 d2 addr", d2, ADDR);
    ceq("R8 d1 etx", d1, 7'h03); ceq("R8 busy", busy, 3'b111);
    ceq("R8 end", end_f, 1); ceq("R8 blocked", shift_en, 0);
    tick; ceq("R8 blocked while scan", shift_en, 0);
    op_found = 1; tick; op_found = 0; #1;
    ceq("R9 bb1 clear", busy, 3'b110); ceq("R9 end clear", end_f, 0);
    ceq("R9 extract", shift_en, 1);
    tick;
    ceq("R9 overwrite", d1, 7'h48); ceq("R9 header kept", d3, 7'h02);
    cursor = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_flow;
    t_etx;
    t_lf;
    t_poll;
    report;
  end
endmodule